// File: doc/BRIEF.md
# Power Mode Clock-Gating Controller

This block decides which clock domains of a processor subsystem run. Software writes a 3-bit mode code, and the block turns it into seven per-domain clock enables. The domains are the core, the timebase/decrementer, the real-time clock, the periodic interrupt timer, the memory controller, the communication module and the PLL. In the doze mode the block also raises a standby flag for the communication module. While the subsystem is fully on, a gear setting divides a core clock-enable strobe so that software can lower the effective core frequency.

The block leaves a low-power mode when a wake event arrives on an input whose enable bit is set. From doze or sleep it returns to Full On on the next clock. From deep sleep or low-power stop the PLL must first relock. The block therefore holds a relock phase in which only the PLL enable is high, and the length of that phase is set by a programmable count. Entry into Full On after a wake raises a one-cycle wake pulse. The analog PLL, the voltage gating and the timers themselves lie outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and just after it, cur_mode reads 000, all seven domain enables are 1, comm_stby is 0 and wake_pulse is 0.
- R2: In Full On, a write (mode_wr high) of code 000 Full On, 001 Doze, 010 Sleep, 011 Deep Sleep or 100 Low Power Stop takes effect at the next clock edge. cur_mode reports the active code and reports 101 during a PLL relock.
- R3: A write of code 101, 110 or 111 is ignored, and the mode stays unchanged.
- R4: A mode write while the block is in any low-power mode is ignored.
- R5: The domain enable bits are [0] core, [1] timebase/decrementer, [2] RTC, [3] periodic timer, [4] memory controller, [5] communication module, [6] PLL. In Doze, every bit except the core bit is 1 and comm_stby is 1.
- R6: In Sleep, only the RTC, periodic timer and PLL bits are 1.
- R7: In Deep Sleep, only the RTC and periodic timer bits are 1.
- R8: In Low Power Stop, all enables are 0 and comm_stby is 0.
- R9: In Doze or Sleep, an event on a wake input whose wake_en bit is 1 returns the block to Full On at the next edge, with wake_pulse high for exactly that one cycle. Events on inputs with wake_en 0 are ignored.
- R10: An enabled wake in Deep Sleep or Low Power Stop starts a relock with count L = lock_cnt. This relock lasts L+1 cycles, during which only the PLL bit is 1. Full On then follows together with the wake pulse.
- R11: In Full On, gear value N makes core_stb high one cycle in every N+1. With N=0, core_stb is high every cycle. Outside Full On, core_stb is 0, and it is high in the first Full On cycle.
- R12: Wake events in Full On or during a relock produce no wake pulse and change no mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_req | input | 3 | Requested mode code |
| gear | input | GEAR_W | Core strobe divider N |
| lock_cnt | input | LOCK_W | PLL relock count L |
| wake_evt | input | WAKE_W | Wake event inputs |
| wake_en | input | WAKE_W | Per-input wake enables |
| dom_en | output | 7 | Per-domain clock enables |
| comm_stby | output | 1 | Communication module standby flag |
| core_stb | output | 1 | Divided core clock-enable strobe |
| wake_pulse | output | 1 | One-cycle wake indication |
| cur_mode | output | 3 | Active mode code |

## Verification
Mode writes and wake events from doze or sleep show on the outputs one edge after the input is sampled. A wake from deep sleep or stop shows the relock code for exactly L+1 cycles, and Full On with the wake pulse appears at L+2. A gear change first affects core_stb at the next edge and then repeats with period N+1. The bench drives inputs at falling edges and queues each expectation under the absolute cycle number in which it is due. A monitor compares outputs at the falling edge of that cycle, so every result is sampled exactly where the count of registers places it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [2:0] {
      PM_FULL   = 3'd0,
      PM_DOZE   = 3'd1,
      PM_SLEEP  = 3'd2,
      PM_DEEP   = 3'd3,
      PM_STOP   = 3'd4,
      PM_RELOCK = 3'd5
   } pm_state_e;

   localparam int NDOM   = 7;
   localparam int D_CORE = 0;
   localparam int D_TB   = 1;
   localparam int D_RTC  = 2;
   localparam int D_PIT  = 3;
   localparam int D_MEM  = 4;
   localparam int D_COMM = 5;
   localparam int D_PLL  = 6;
   localparam logic [2:0] LAST_CODE = 3'd4;
endpackage

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
   parameter int WAKE_W = 3
) (
   input  logic [WAKE_W-1:0] evt,
   input  logic [WAKE_W-1:0] en,
   output logic              any
);
   assign any = |(evt & en);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
#(
   parameter int LOCK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_req,
   input  logic              wake_any,
   input  logic [LOCK_W-1:0] lock_cnt,
   output pm_state_e         state,
   output logic              wake_pulse
);
   pm_state_e         st_n;
   logic [LOCK_W-1:0] cnt, cnt_n;
   logic              pulse_n;

   always_comb begin
      st_n    = state;
      cnt_n   = cnt;
      pulse_n = 1'b0;
      case (state)
         PM_FULL: begin
            if (mode_wr && (mode_req <= LAST_CODE))
               st_n = pm_state_e'(mode_req);
         end
         PM_DOZE, PM_SLEEP: begin
            if (wake_any) begin
               st_n    = PM_FULL;
               pulse_n = 1'b1;
            end
         end
         PM_DEEP, PM_STOP: begin
            if (wake_any) begin
               st_n  = PM_RELOCK;
               cnt_n = lock_cnt;
            end
         end
         PM_RELOCK: begin
            if (cnt == '0) begin
               st_n    = PM_FULL;
               pulse_n = 1'b1;
            end else begin
               cnt_n = cnt - 1'b1;
            end
         end
         default: st_n = PM_FULL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= PM_FULL;
         cnt        <= '0;
         wake_pulse <= 1'b0;
      end else begin
         state      <= st_n;
         cnt        <= cnt_n;
         wake_pulse <= pulse_n;
      end
   end
endmodule

// File: rtl/pmc_gear_div.sv
module pmc_gear_div #(
   parameter int GEAR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [GEAR_W-1:0] gear,
   output logic              stb
);
   logic [GEAR_W-1:0] gcnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         gcnt <= '0;
      else if (gcnt >= gear)
         gcnt <= '0;
      else
         gcnt <= gcnt + 1'b1;
   end

   assign stb = run && (gcnt == '0);
endmodule

// File: rtl/pmc_dom_decode.sv
module pmc_dom_decode
   import pmc_pkg::*;
#(
   parameter bit COMM_GATE_DOZE = 1'b0
) (
   input  pm_state_e        state,
   output logic [NDOM-1:0]  dom_en,
   output logic             comm_stby
);
   logic doze_comm;

   generate
      if (COMM_GATE_DOZE) begin : g_gate
         assign doze_comm = 1'b0;
      end else begin : g_keep
         assign doze_comm = 1'b1;
      end
   endgenerate

   always_comb begin
      dom_en    = '0;
      comm_stby = 1'b0;
      case (state)
         PM_FULL: dom_en = '1;
         PM_DOZE: begin
            dom_en         = '1;
            dom_en[D_CORE] = 1'b0;
            dom_en[D_COMM] = doze_comm;
            comm_stby      = 1'b1;
         end
         PM_SLEEP: begin
            dom_en[D_RTC] = 1'b1;
            dom_en[D_PIT] = 1'b1;
            dom_en[D_PLL] = 1'b1;
         end
         PM_DEEP: begin
            dom_en[D_RTC] = 1'b1;
            dom_en[D_PIT] = 1'b1;
         end
         PM_RELOCK: dom_en[D_PLL] = 1'b1;
         default: dom_en = '0;
      endcase
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int GEAR_W         = 4,
   parameter int LOCK_W         = 8,
   parameter int WAKE_W         = 3,
   parameter bit COMM_GATE_DOZE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_req,
   input  logic [GEAR_W-1:0] gear,
   input  logic [LOCK_W-1:0] lock_cnt,
   input  logic [WAKE_W-1:0] wake_evt,
   input  logic [WAKE_W-1:0] wake_en,
   output logic [6:0]        dom_en,
   output logic              comm_stby,
   output logic              core_stb,
   output logic              wake_pulse,
   output logic [2:0]        cur_mode
);
   generate
      if (GEAR_W < 1 || GEAR_W > 16) begin : g_bad_gear
         $error("GEAR_W out of range");
      end
      if (LOCK_W < 1 || LOCK_W > 24) begin : g_bad_lock
         $error("LOCK_W out of range");
      end
      if (WAKE_W < 1) begin : g_bad_wake
         $error("WAKE_W must be positive");
      end
   endgenerate

   pm_state_e state;
   logic      wake_any;

   pmc_wake_detect #(.WAKE_W(WAKE_W)) u_wake (
      .evt (wake_evt),
      .en  (wake_en),
      .any (wake_any)
   );

   pmc_mode_fsm #(.LOCK_W(LOCK_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_req   (mode_req),
      .wake_any   (wake_any),
      .lock_cnt   (lock_cnt),
      .state      (state),
      .wake_pulse (wake_pulse)
   );

   pmc_gear_div #(.GEAR_W(GEAR_W)) u_gear (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == PM_FULL),
      .gear  (gear),
      .stb   (core_stb)
   );

   pmc_dom_decode #(.COMM_GATE_DOZE(COMM_GATE_DOZE)) u_dec (
      .state     (state),
      .dom_en    (dom_en),
      .comm_stby (comm_stby)
   );

   assign cur_mode = state;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
   parameter int GEAR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_wr,
   input logic [2:0]        mode_req,
   input logic [GEAR_W-1:0] gear,
   input logic [6:0]        dom_en,
   input logic              comm_stby,
   input logic              core_stb,
   input logic              wake_pulse,
   input logic [2:0]        cur_mode
);
   assert_stop_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd4) |-> (dom_en == 7'h00 && !comm_stby));

   assert_relock_pll_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd5) |-> (dom_en == 7'h40));

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   assert_pulse_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (cur_mode == 3'd0 && $past(cur_mode) != 3'd0));

   assert_bad_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd0 && mode_wr && mode_req > 3'd4) |=> (cur_mode == 3'd0));

   assert_core_only_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dom_en[0] |-> (cur_mode == 3'd0));

   assert_stb_needs_core_R11: assert property (@(posedge clk) disable iff (!rst_n)
      core_stb |-> dom_en[0]);

   assert_gear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 3'd0 && $past(cur_mode) == 3'd0 && $past(gear) == '0) |-> core_stb);
endmodule

bind pwr_mode_ctrl pmc_checker #(.GEAR_W(GEAR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_wr    (mode_wr),
   .mode_req   (mode_req),
   .gear       (gear),
   .dom_en     (dom_en),
   .comm_stby  (comm_stby),
   .core_stb   (core_stb),
   .wake_pulse (wake_pulse),
   .cur_mode   (cur_mode)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic [2:0] mode_req = '0;
   logic [3:0] gear = '0;
   logic [7:0] lock_cnt = 8'd3;
   logic [2:0] wake_evt = '0;
   logic [2:0] wake_en = 3'b011;
   logic [6:0] dom_en;
   logic       comm_stby, core_stb, wake_pulse;
   logic [2:0] cur_mode;

   pwr_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_req(mode_req),
      .gear(gear), .lock_cnt(lock_cnt), .wake_evt(wake_evt), .wake_en(wake_en),
      .dom_en(dom_en), .comm_stby(comm_stby), .core_stb(core_stb),
      .wake_pulse(wake_pulse), .cur_mode(cur_mode)
   );

   always #5 clk = ~clk;

   localparam logic [12:0] MSTB = 13'h0100;
   localparam logic [12:0] MWP  = 13'h0200;
   localparam logic [12:0] MALL = 13'h1FFF;

   typedef struct {
      int          at;
      logic [12:0] mask;
      logic [12:0] val;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [12:0] pk(logic [2:0] m, logic wp, logic st,
                                      logic sb_f, logic [6:0] d);
      return {m, wp, st, sb_f, d};
   endfunction

   // monitor: compare every queued item that is due in this cycle
   always @(negedge clk) begin
      logic [12:0] obs;
      obs = {cur_mode, wake_pulse, core_stb, comm_stby, dom_en};
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].at <= cyc) begin
            checks++;
            if ((obs & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
               fails++;
               $display("FAIL %s cycle %0d: actual %h expected %h (mask %h)",
                        sb[i].tag, cyc, obs & sb[i].mask,
                        sb[i].val & sb[i].mask, sb[i].mask);
            end
            sb.delete(i);
         end
      end
   end

   task automatic want(int dt, logic [12:0] m, logic [12:0] v, string t);
      exp_t e;
      e.at = cyc + dt; e.mask = m; e.val = v; e.tag = t;
      sb.push_back(e);
   endtask

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_mode(logic [2:0] code);
      mode_wr = 1'b1; mode_req = code;
      hold(1);
      mode_wr = 1'b0;
   endtask

   task automatic wake(logic [2:0] b);
      wake_evt = b;
      hold(1);
      wake_evt = '0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      hold(2);
      want(1, MALL, pk(3'd0, 0, 1, 0, 7'h7F), "R1 reset state");
      hold(1);
      rst_n = 1'b1;
      want(1, MALL, pk(3'd0, 0, 1, 0, 7'h7F), "R1 after reset");
      hold(2);

      // R11 gear divider N=2 then N=0
      gear = 4'd2;
      want(1, MSTB, 13'h0000, "R11 gear2 c1");
      want(2, MSTB, 13'h0000, "R11 gear2 c2");
      want(3, MSTB, MSTB,     "R11 gear2 c3");
      want(4, MSTB, 13'h0000, "R11 gear2 c4");
      want(5, MSTB, 13'h0000, "R11 gear2 c5");
      want(6, MSTB, MSTB,     "R11 gear2 c6");
      hold(6);
      gear = 4'd0;
      for (int k = 1; k <= 3; k++) want(k, MSTB, MSTB, "R11 gear0");
      hold(3);

      // R3 invalid code
      want(1, MALL, pk(3'd0, 0, 1, 0, 7'h7F), "R3 code 110 ignored");
      want(2, MALL, pk(3'd0, 0, 1, 0, 7'h7F), "R3 code 110 ignored later");
      wr_mode(3'b110);
      hold(2);

      // R12 wake in Full On
      want(1, MALL, pk(3'd0, 0, 1, 0, 7'h7F), "R12 wake in full on");
      wake(3'b001);
      hold(2);

      // R2 R5 Doze
      want(1, MALL, pk(3'd1, 0, 0, 1, 7'h7E), "R5 R2 doze enables");
      wr_mode(3'd1);
      hold(1);
      // R4 write in low power ignored
      want(1, MALL, pk(3'd1, 0, 0, 1, 7'h7E), "R4 write in doze ignored");
      wr_mode(3'd2);
      hold(1);
      // R9 masked wake ignored
      want(1, MALL, pk(3'd1, 0, 0, 1, 7'h7E), "R9 masked wake ignored");
      wake(3'b100);
      hold(1);
      // R9 enabled wake
      want(1, MALL, pk(3'd0, 1, 1, 0, 7'h7F), "R9 doze wake");
      want(2, MWP, 13'h0000, "R9 pulse one cycle");
      wake(3'b001);
      hold(3);

      // R6 Sleep
      want(1, MALL, pk(3'd2, 0, 0, 0, 7'h4C), "R6 sleep enables");
      wr_mode(3'd2);
      hold(1);
      want(1, MALL, pk(3'd0, 1, 1, 0, 7'h7F), "R9 sleep wake");
      wake(3'b010);
      hold(3);

      // R7 Deep Sleep, R10 relock with L=3
      want(1, MALL, pk(3'd3, 0, 0, 0, 7'h0C), "R7 deep sleep enables");
      wr_mode(3'd3);
      hold(1);
      for (int k = 1; k <= 4; k++)
         want(k, MALL, pk(3'd5, 0, 0, 0, 7'h40), "R10 relock L3");
      want(5, MALL, pk(3'd0, 1, 1, 0, 7'h7F), "R10 full after relock");
      want(6, MWP, 13'h0000, "R10 pulse ends");
      wake(3'b001);
      hold(6);

      // R8 Stop, R10 relock with L=2, R12 wake during relock
      lock_cnt = 8'd2;
      want(1, MALL, pk(3'd4, 0, 0, 0, 7'h00), "R8 stop all off");
      wr_mode(3'd4);
      hold(1);
      for (int k = 1; k <= 3; k++)
         want(k, MALL, pk(3'd5, 0, 0, 0, 7'h40), "R10 R12 relock L2");
      want(4, MALL, pk(3'd0, 1, 1, 0, 7'h7F), "R10 full after stop");
      want(5, MWP, 13'h0000, "R10 stop pulse ends");
      wake(3'b001);
      wake(3'b011);
      hold(5);

      // R10 relock with L=0 from Stop
      lock_cnt = 8'd0;
      wr_mode(3'd4);
      hold(1);
      want(1, MALL, pk(3'd5, 0, 0, 0, 7'h40), "R10 relock L0");
      want(2, MALL, pk(3'd0, 1, 1, 0, 7'h7F), "R10 full after L0");
      wake(3'b010);
      hold(4);

      while (sb.size() != 0) hold(1);
      done = 1;
      finish_run();
   end
endmodule